// File: doc/BRIEF.md
# Flash Status Byte and Write Guard

This block keeps the status byte of a serial flash device and decides, in the same clock cycle that a decoded command strobe arrives, whether that command may run. It holds the write-enable latch, the two protection-size bits, the top/bottom selector and the lock bit. It also tracks the busy flag of the self-timed engine that it starts. The command decoder raises one single-cycle strobe per command, together with the target address. The block answers with a grant for that command. The array engine, which is outside this block, starts only on a grant and reports the end of its work with a single-cycle done pulse.

Protection is checked against the full region that an operation touches: a 256-byte page, a 4 KB sector or a 64 KB block. Any overlap with the protected range refuses the command. A refused command changes nothing. The lock bit freezes the protection fields only while the write-protect pin is held low. Reset values of the protection fields are parameters, because non-volatile storage of these bits is handled elsewhere.

Top module: `flash_status_guard`

## Requirements
- R1: After reset, status_o equals {RST_BPL,0,RST_TB,0,RST_BP[1],RST_BP[0],0,0}, which is 0x00 with the default parameters.
- R2: status_o bit 0 is BUSY, bit 1 is WEL, bits 2 and 3 are the size bits S0 and S1, bit 5 is the bottom selector, and bit 7 is the lock bit. Bits 4 and 6 always read 0.
- R3: When not busy, a write-enable strobe sets WEL and a write-disable strobe clears it. Both take effect in the cycle after the strobe.
- R4: A status write is granted (wrsr_ok_o high in the strobe cycle) only when WEL is 1, BUSY is 0, and the pair (wp_n = 0, lock = 1) does not hold. On a grant, data bits 2, 3, 5 and 7 are loaded into the same status bit positions on the next cycle. When wp_n is high, the lock bit has no effect.
- R5: Protected range, written with size bits {S1,S0} over an array of 2^ADDR_W bytes:
  - 00 protects nothing.
  - 11 protects the whole array.
  - With the bottom selector at 0, 01 protects the top quarter and 10 protects the top half.
  - With the bottom selector at 1, 01 protects the bottom quarter and 10 protects the bottom half.
  - With ADDR_W = 18, the top quarter is 0x30000–0x3FFFF and the bottom quarter is 0x00000–0x0FFFF.
- R6: Program, sector erase and block erase are granted only when WEL is 1, BUSY is 0, and the aligned region (256 B, 4 KB or 64 KB) containing op_addr_i has no byte in the protected range.
- R7: Chip erase is granted only when WEL is 1, BUSY is 0 and both size bits are 0. The bottom selector and the lock bit do not matter.
- R8: Any grant sets BUSY on the next cycle. A refused command leaves BUSY at 0 and WEL unchanged.
- R9: done_i while BUSY is 1 clears BUSY and WEL on the next cycle. done_i while BUSY is 0 has no effect.
- R10: While BUSY is 1, every command is refused, and write-enable and write-disable strobes leave WEL unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin level, low arms the lock bit |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status-write command strobe |
| wrsr_byte_i | input | 8 | Data byte of the status write |
| prog_i | input | 1 | Page-program request strobe |
| sect_erase_i | input | 1 | Sector-erase request strobe |
| blk_erase_i | input | 1 | Block-erase request strobe |
| chip_erase_i | input | 1 | Chip-erase request strobe |
| done_i | input | 1 | Completion pulse from the array engine |
| op_addr_i | input | ADDR_W | Target byte address of the request |
| status_o | output | 8 | Status byte |
| wrsr_ok_o | output | 1 | Status write granted |
| prog_ok_o | output | 1 | Program granted |
| sect_ok_o | output | 1 | Sector erase granted |
| blk_ok_o | output | 1 | Block erase granted |
| chip_ok_o | output | 1 | Chip erase granted |

## Verification
Directed sequences walk the protection decode through every combination of the size bits and the selector. They probe addresses just inside and just outside each quarter boundary, which separates a first-byte check from a whole-region check. The lock is exercised with the pin low and then high, which tells a frozen status write apart from one the pin releases. A long run of random strobes, addresses, data bytes and pin levels, with done pulses mixed in, then compares every output each cycle against a behavioural model. That run catches ordering faults such as commands leaking through while busy, or latch clears that are missing on completion.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef struct packed {
    logic       lock;
    logic       bottom;
    logic [1:0] size;
  } prot_t;

  // 1 when quarter q of the array lies inside the protected range
  function automatic logic quarter_hit(prot_t p, logic [1:0] q);
    logic r;
    case (p.size)
      2'b00:   r = 1'b0;
      2'b01:   r = p.bottom ? (q == 2'b00) : (q == 2'b11);
      2'b10:   r = p.bottom ? ~q[1] : q[1];
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] pack_status(prot_t p, logic wel, logic busy);
    return {p.lock, 1'b0, p.bottom, 1'b0, p.size, wel, busy};
  endfunction

endpackage

// File: rtl/fsg_region_check.sv
module fsg_region_check
  import fsg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned SPAN_LOG2 = 12
) (
  input  prot_t             prot,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // which of the two top address bits stay fixed across an aligned region
  localparam logic [1:0] QKEEP = (SPAN_LOG2 >= ADDR_W)     ? 2'b00 :
                                 (SPAN_LOG2 == ADDR_W - 1) ? 2'b10 : 2'b11;

  logic [1:0] q_first, q_last;
  logic       unused_addr_low;

  assign unused_addr_low = ^addr;
  assign q_first = addr[ADDR_W-1 -: 2] & QKEEP;
  assign q_last  = addr[ADDR_W-1 -: 2] | ~QKEEP;

  // protection boundaries sit on quarters, so checking the end quarters covers the region
  assign hit = quarter_hit(prot, q_first) | quarter_hit(prot, q_last);
endmodule

// File: rtl/fsg_wel_busy.sv
module fsg_wel_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wel,
  input  logic clr_wel,
  input  logic start,
  input  logic done,
  output logic wel,
  output logic busy
);
  logic finish;
  assign finish = done & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      busy <= 1'b0;
    end else begin
      if (finish) begin
        wel  <= 1'b0;
        busy <= 1'b0;
      end else begin
        if (start)        busy <= 1'b1;
        if (set_wel)      wel  <= 1'b1;
        else if (clr_wel) wel  <= 1'b0;
      end
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R8

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |=> (!busy && !wel)); // R9

  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !busy && !start && !set_wel && !clr_wel) |=> ($stable(wel) && !busy)); // R9
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned PAGE_LOG2 = 8,
  parameter int unsigned SECT_LOG2 = 12,
  parameter int unsigned BLK_LOG2  = 16,
  parameter bit [1:0]    RST_BP    = 2'b00,
  parameter bit          RST_TB    = 1'b0,
  parameter bit          RST_BPL   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_byte_i,
  input  logic              prog_i,
  input  logic              sect_erase_i,
  input  logic              blk_erase_i,
  input  logic              chip_erase_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  output logic [7:0]        status_o,
  output logic              wrsr_ok_o,
  output logic              prog_ok_o,
  output logic              sect_ok_o,
  output logic              blk_ok_o,
  output logic              chip_ok_o
);
  localparam int unsigned N_ARR = 3;
  localparam int unsigned SPAN_TAB [N_ARR] = '{PAGE_LOG2, SECT_LOG2, BLK_LOG2};

  prot_t             prot_q;
  logic              wel, busy, free, lock_hold, start;
  logic [N_ARR-1:0]  arr_req, arr_hit, arr_ok;
  logic              unused_byte_bits;

  assign unused_byte_bits = wrsr_byte_i[6] ^ wrsr_byte_i[4] ^ wrsr_byte_i[1] ^ wrsr_byte_i[0];

  assign free      = wel & ~busy;
  assign lock_hold = ~wp_n & prot_q.lock;
  assign arr_req   = {blk_erase_i, sect_erase_i, prog_i};

  generate
    for (genvar g = 0; g < N_ARR; g++) begin : g_region
      fsg_region_check #(
        .ADDR_W   (ADDR_W),
        .SPAN_LOG2(SPAN_TAB[g])
      ) u_chk (
        .prot(prot_q),
        .addr(op_addr_i),
        .hit (arr_hit[g])
      );
      assign arr_ok[g] = arr_req[g] & free & ~arr_hit[g];
    end
  endgenerate

  assign wrsr_ok_o = wrsr_i & free & ~lock_hold;
  assign prog_ok_o = arr_ok[0];
  assign sect_ok_o = arr_ok[1];
  assign blk_ok_o  = arr_ok[2];
  assign chip_ok_o = chip_erase_i & free & (prot_q.size == 2'b00);
  assign start     = wrsr_ok_o | (|arr_ok) | chip_ok_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= '{lock: RST_BPL, bottom: RST_TB, size: RST_BP};
    end else if (wrsr_ok_o) begin
      prot_q <= '{lock: wrsr_byte_i[7], bottom: wrsr_byte_i[5],
                  size: wrsr_byte_i[3:2]};
    end
  end

  fsg_wel_busy u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wel(wren_i & ~busy),
    .clr_wel(wrdi_i & ~busy),
    .start  (start),
    .done   (done_i),
    .wel    (wel),
    .busy   (busy)
  );

  assign status_o = pack_status(prot_q, wel, busy);

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !wp_n && prot_q.lock) |=> $stable(prot_q)); // R4

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(wrsr_ok_o || prog_ok_o || sect_ok_o || blk_ok_o || chip_ok_o)); // R10

  AST_NO_WEL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[1] |-> !(wrsr_ok_o || prog_ok_o || sect_ok_o || blk_ok_o || chip_ok_o)); // R6

  AST_REFUSED_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_i || sect_erase_i || blk_erase_i || chip_erase_i || wrsr_i) && !start)
      |=> ($stable(wel) && $stable(busy))); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] == 1'b0) && (status_o[6] == 1'b0)); // R2

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrsr_ok_o, prog_ok_o, sect_ok_o, blk_ok_o, chip_ok_o})); // R8
endmodule

// File: tb/flash_status_guard_tb_top.sv
`timescale 1ns/100ps
module flash_status_guard_tb_top;
  localparam int AW = 18;
  localparam int K_IDLE = 0, K_WREN = 1, K_WRDI = 2, K_WRSR = 3, K_PROG = 4,
                 K_SECT = 5, K_BLK = 6, K_CHIP = 7, K_DONE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic wren_i = 0, wrdi_i = 0, wrsr_i = 0, prog_i = 0, sect_erase_i = 0;
  logic blk_erase_i = 0, chip_erase_i = 0, done_i = 0;
  logic [7:0] wrsr_byte_i = '0;
  logic [AW-1:0] op_addr_i = '0;
  logic [7:0] status_o;
  logic wrsr_ok_o, prog_ok_o, sect_ok_o, blk_ok_o, chip_ok_o;

  int compared = 0, mismatched = 0;
  // reference model state
  int m_wel = 0, m_busy = 0, m_s0 = 0, m_s1 = 0, m_tb = 0, m_bpl = 0;
  // grants seen during the most recent step
  int g_wrsr, g_prog, g_sect, g_blk, g_chip;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_status_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .wrsr_i(wrsr_i), .wrsr_byte_i(wrsr_byte_i), .prog_i(prog_i),
    .sect_erase_i(sect_erase_i), .blk_erase_i(blk_erase_i),
    .chip_erase_i(chip_erase_i), .done_i(done_i), .op_addr_i(op_addr_i),
    .status_o(status_o), .wrsr_ok_o(wrsr_ok_o), .prog_ok_o(prog_ok_o),
    .sect_ok_o(sect_ok_o), .blk_ok_o(blk_ok_o), .chip_ok_o(chip_ok_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // protected interval as integer bounds, compared against [base,last]
  function automatic int m_hit(int base, int last);
    int sz, len, lo, hi, bp;
    sz = 1 << AW;
    bp = m_s1 * 2 + m_s0;
    if (bp == 0) return 0;
    len = (bp == 1) ? sz / 4 : (bp == 2) ? sz / 2 : sz;
    if (m_tb != 0) begin lo = 0; hi = len - 1; end
    else begin lo = sz - len; hi = sz - 1; end
    return (last < lo || base > hi) ? 0 : 1;
  endfunction

  function automatic int m_region_ok(int a, int span);
    int base;
    base = (a / span) * span;
    return (m_hit(base, base + span - 1) == 0) ? 1 : 0;
  endfunction

  task automatic step(input int kind, input int addr, input int data, input bit wp);
    int e_status, e_wrsr, e_prog, e_sect, e_blk, e_chip, free;
    @(negedge clk);
    wren_i = (kind == K_WREN); wrdi_i = (kind == K_WRDI); wrsr_i = (kind == K_WRSR);
    prog_i = (kind == K_PROG); sect_erase_i = (kind == K_SECT);
    blk_erase_i = (kind == K_BLK); chip_erase_i = (kind == K_CHIP);
    done_i = (kind == K_DONE);
    op_addr_i = addr[AW-1:0]; wrsr_byte_i = data[7:0]; wp_n = wp;
    #1;
    free = (m_wel != 0 && m_busy == 0) ? 1 : 0;
    e_status = m_bpl * 128 + m_tb * 32 + m_s1 * 8 + m_s0 * 4 + m_wel * 2 + m_busy;
    e_wrsr = (kind == K_WRSR && free != 0 && !(wp == 1'b0 && m_bpl != 0)) ? 1 : 0;
    e_prog = (kind == K_PROG && free != 0) ? m_region_ok(addr, 256) : 0;
    e_sect = (kind == K_SECT && free != 0) ? m_region_ok(addr, 4096) : 0;
    e_blk  = (kind == K_BLK && free != 0) ? m_region_ok(addr, 65536) : 0;
    e_chip = (kind == K_CHIP && free != 0 && m_s0 == 0 && m_s1 == 0) ? 1 : 0;
    g_wrsr = int'(wrsr_ok_o); g_prog = int'(prog_ok_o); g_sect = int'(sect_ok_o);
    g_blk = int'(blk_ok_o); g_chip = int'(chip_ok_o);
    chk("R2 status byte", int'(status_o), e_status);
    chk("R4 status write grant", g_wrsr, e_wrsr);
    chk("R6 program grant", g_prog, e_prog);
    chk("R6 sector erase grant", g_sect, e_sect);
    chk("R6 block erase grant", g_blk, e_blk);
    chk("R7 chip erase grant", g_chip, e_chip);
    @(posedge clk);
    if (kind == K_DONE && m_busy != 0) begin
      m_busy = 0; m_wel = 0;
    end else begin
      if (kind == K_WREN && m_busy == 0) m_wel = 1;
      if (kind == K_WRDI && m_busy == 0) m_wel = 0;
      if (e_wrsr != 0) begin
        m_s0 = (data >> 2) & 1; m_s1 = (data >> 3) & 1;
        m_tb = (data >> 5) & 1; m_bpl = (data >> 7) & 1;
      end
      if ((e_wrsr | e_prog | e_sect | e_blk | e_chip) != 0) m_busy = 1;
    end
    #1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int k, a, d;
    bit w;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1 reset status", int'(status_o), 8'h00);

    step(K_WRSR, 0, 8'h24, 1);  chk("R4 refused without WEL", g_wrsr, 0);
    step(K_WREN, 0, 0, 1);      chk("R3 write enable sets WEL", int'(status_o), 8'h02);
    step(K_WRSR, 0, 8'h24, 1);  chk("R4 granted with WEL", g_wrsr, 1);
    chk("R8 grant sets BUSY", int'(status_o), 8'h27);
    step(K_DONE, 0, 0, 1);      chk("R9 done clears BUSY and WEL", int'(status_o), 8'h24);
    step(K_DONE, 0, 0, 1);      chk("R9 idle done no effect", int'(status_o), 8'h24);
    step(K_WREN, 0, 0, 1);
    step(K_SECT, 32'h0F123, 0, 1); chk("R5 bottom quarter sector denied", g_sect, 0);
    chk("R8 refused keeps WEL, no BUSY", int'(status_o), 8'h26);
    step(K_BLK, 32'h1FFFF, 0, 1);  chk("R6 block above quarter granted", g_blk, 1);
    step(K_WRDI, 0, 0, 1);      chk("R10 disable ignored while busy", int'(status_o), 8'h27);
    step(K_PROG, 32'h20000, 0, 1); chk("R10 program refused while busy", g_prog, 0);
    step(K_DONE, 0, 0, 1);
    step(K_WREN, 0, 0, 1);
    step(K_CHIP, 0, 0, 1);      chk("R7 chip erase refused with size bits", g_chip, 0);
    step(K_WRDI, 0, 0, 1);      chk("R3 write disable clears WEL", int'(status_o), 8'h24);
    step(K_PROG, 32'h3FF00, 0, 1); chk("R6 program refused without WEL", g_prog, 0);

    step(K_WREN, 0, 0, 1);
    step(K_WRSR, 0, 8'hA8, 0);  chk("R4 lock set while pin low and unlocked", g_wrsr, 1);
    step(K_DONE, 0, 0, 1);      chk("R2 lock and bottom half fields", int'(status_o), 8'hA8);
    step(K_WREN, 0, 0, 0);
    step(K_WRSR, 0, 8'h00, 0);  chk("R4 locked status write refused", g_wrsr, 0);
    chk("R4 locked fields unchanged", int'(status_o), 8'hAA);
    step(K_PROG, 32'h1FFFF, 0, 0); chk("R5 bottom half program denied", g_prog, 0);
    step(K_PROG, 32'h20000, 0, 0); chk("R5 upper half program granted", g_prog, 1);
    step(K_DONE, 0, 0, 1);
    step(K_WREN, 0, 0, 1);
    step(K_WRSR, 0, 8'hFF, 1);  chk("R4 pin high releases lock", g_wrsr, 1);
    step(K_DONE, 0, 0, 1);      chk("R2 reserved bits read zero", int'(status_o), 8'hAC);
    step(K_WREN, 0, 0, 1);
    step(K_WRSR, 0, 8'h04, 1);
    step(K_DONE, 0, 0, 1);
    step(K_WREN, 0, 0, 1);
    step(K_SECT, 32'h2F000, 0, 1); chk("R5 sector below top quarter granted", g_sect, 1);
    step(K_DONE, 0, 0, 1);
    step(K_WREN, 0, 0, 1);
    step(K_SECT, 32'h30000, 0, 1); chk("R5 top quarter sector denied", g_sect, 0);
    step(K_WRSR, 0, 8'h20, 1);
    step(K_DONE, 0, 0, 1);
    step(K_WREN, 0, 0, 1);
    step(K_CHIP, 0, 0, 1);      chk("R7 chip erase with size bits clear", g_chip, 1);
    step(K_DONE, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      k = $urandom % 12;
      if (k > 8) k = (k == 9) ? K_WREN : K_DONE;
      a = $urandom % (1 << AW);
      d = $urandom % 256;
      w = ($urandom % 4) != 0;
      step(k, a, d, w);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule